// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the phase timing for a single analog-to-digital conversion. A programmable power-of-two ratio divides the module clock to form a converter clock. The sample phase lasts a base of four converter-clock cycles, and a long-sample code can stretch it. A conversion phase of fixed length follows. The analog converter is not modelled here. Its only stand-in is the length of the conversion phase.

A start pulse launches a conversion when the block is idle. At that moment the block captures the divider code and the decoded sample length, and it holds both until the conversion ends. The block drives a strobe for each phase, a busy flag and a sticky done flag. In continuous mode it begins the next conversion in the cycle that the previous one completes, and it captures the codes again at that point. An abort input returns the block to idle at once.

Top module: `adc_conv_sequencer`

## Requirements
- R1: The divider code sets the module-clock cycles per converter-clock cycle: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. Both phase lengths scale by this ratio.
- R2: The sample phase lasts this many converter-clock cycles for each long-sample code: 24 for code 0, 16 for code 1, 10 for code 2 and 6 for code 3.
- R3: Long-sample codes 4 to 7 turn off the extension, and the sample phase then lasts the base 4 converter-clock cycles.
- R4: The conversion phase lasts CONV_CYCLES converter-clock cycles (default 20) and begins in the cycle right after the last sample cycle. sample_o and convert_o are never high together.
- R5: In the cycle after an accepted start (start_i high while idle, abort_i low), busy_o and sample_o are high. busy_o stays high through both phases. A start_i that arrives while busy has no effect on the phase lengths.
- R6: done_o rises in the cycle after the last conversion cycle, and busy_o falls in that same cycle. done_o then stays high until a clear_i pulse or an accepted start.
- R7: With cont_en_i high at completion, sample_o rises again in the cycle that done_o rises. The new conversion uses the codes present at that completion edge, and done_o stays high.
- R8: abort_i while busy returns the block to idle in the next cycle. done_o is left unchanged, so a conversion that is aborted never sets it.
- R9: A change to div_code_i or ls_code_i during a conversion does not alter that conversion's phase lengths.
- R10: After reset, busy_o, done_o, sample_o and convert_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| abort_i | input | 1 | Abort the running conversion |
| clear_i | input | 1 | Clear the done flag |
| div_code_i | input | 2 | Converter clock divider code |
| ls_code_i | input | 3 | Long-sample code |
| cont_en_i | input | 1 | Continuous-mode enable |
| sample_o | output | 1 | High during the sample phase |
| convert_o | output | 1 | High during the conversion phase |
| busy_o | output | 1 | High while a conversion runs |
| done_o | output | 1 | Sticky conversion-complete flag |

## Verification
Every output comes from a register. A start, abort or clear therefore shows up one module-clock cycle after the edge that samples it. With a divide ratio R, the sample phase lasts the sample length times R cycles, and the conversion phase lasts CONV_CYCLES times R cycles. The bench drives inputs and samples outputs at the falling edge. It counts the falling edges at which each strobe is high and compares those counts with lengths it works out from the codes. It checks done_o and busy_o at the first falling edge after convert_o drops, and it checks the effect of an abort or clear at the falling edge after the pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_e;

    // Extra converter-clock cycles added to the base sample phase, per code
    localparam int unsigned LS_EXTRA0 = 20;
    localparam int unsigned LS_EXTRA1 = 12;
    localparam int unsigned LS_EXTRA2 = 6;
    localparam int unsigned LS_EXTRA3 = 2;
    localparam int unsigned LS_EXTRA_MAX = LS_EXTRA0;

endpackage

// File: rtl/adc_seq_tickgen.sv
// Converter-clock enable: one-cycle tick every 2**div_code module clocks
module adc_seq_tickgen #(
    parameter int unsigned DIV_CODE_W = 2,
    parameter int unsigned CNT_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic [DIV_CODE_W-1:0] div_code,
    output logic                  tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim   = CNT_W'((1 << div_code) - 1);
        tick  = (cnt_q == lim);
        cnt_d = (restart || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_samplen.sv
// Decodes the long-sample code into a total sample length in converter cycles
module adc_seq_samplen
    import adc_seq_pkg::*;
#(
    parameter int unsigned LS_CODE_W   = 3,
    parameter int unsigned BASE_SAMPLE = 4,
    parameter int unsigned LEN_W       = 5
) (
    input  logic [LS_CODE_W-1:0] ls_code,
    output logic [LEN_W-1:0]     len
);
    always_comb begin
        case (ls_code)
            LS_CODE_W'(0): len = LEN_W'(BASE_SAMPLE + LS_EXTRA0);
            LS_CODE_W'(1): len = LEN_W'(BASE_SAMPLE + LS_EXTRA1);
            LS_CODE_W'(2): len = LEN_W'(BASE_SAMPLE + LS_EXTRA2);
            LS_CODE_W'(3): len = LEN_W'(BASE_SAMPLE + LS_EXTRA3);
            default:       len = LEN_W'(BASE_SAMPLE);
        endcase
    end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned DIV_CODE_W  = 2,
    parameter int unsigned LS_CODE_W   = 3,
    parameter int unsigned BASE_SAMPLE = 4,
    parameter int unsigned CONV_CYCLES = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  abort_i,
    input  logic                  clear_i,
    input  logic [DIV_CODE_W-1:0] div_code_i,
    input  logic [LS_CODE_W-1:0]  ls_code_i,
    input  logic                  cont_en_i,
    output logic                  sample_o,
    output logic                  convert_o,
    output logic                  busy_o,
    output logic                  done_o
);
    localparam int unsigned MAX_RATIO = 1 << ((1 << DIV_CODE_W) - 1);
    localparam int unsigned DIVCNT_W  = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;
    localparam int unsigned MAX_SAMP  = BASE_SAMPLE + LS_EXTRA_MAX;
    localparam int unsigned PH_MAX    = (MAX_SAMP > CONV_CYCLES) ? MAX_SAMP : CONV_CYCLES;
    localparam int unsigned PHCNT_W   = $clog2(PH_MAX + 1);

    typedef struct packed {
        phase_e                ph;
        logic [PHCNT_W-1:0]    cnt;
        logic [DIV_CODE_W-1:0] div;
        logic [PHCNT_W-1:0]    slen;
        logic                  done;
    } seq_t;

    seq_t               cur_q, nxt_d;
    logic               tick;
    logic [PHCNT_W-1:0] dec_len;

    adc_seq_tickgen #(
        .DIV_CODE_W(DIV_CODE_W),
        .CNT_W     (DIVCNT_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cur_q.ph == PH_IDLE),
        .div_code(cur_q.div),
        .tick    (tick)
    );

    adc_seq_samplen #(
        .LS_CODE_W  (LS_CODE_W),
        .BASE_SAMPLE(BASE_SAMPLE),
        .LEN_W      (PHCNT_W)
    ) u_slen (
        .ls_code(ls_code_i),
        .len    (dec_len)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = cur_q.done & ~clear_i;
        if (abort_i && cur_q.ph != PH_IDLE) begin
            nxt_d.ph  = PH_IDLE;
            nxt_d.cnt = '0;
        end else begin
            case (cur_q.ph)
                PH_IDLE: begin
                    if (start_i && !abort_i) begin
                        nxt_d.ph   = PH_SAMPLE;
                        nxt_d.cnt  = '0;
                        nxt_d.div  = div_code_i;
                        nxt_d.slen = dec_len;
                        nxt_d.done = 1'b0;
                    end
                end
                PH_SAMPLE: begin
                    if (tick) begin
                        if (cur_q.cnt == cur_q.slen - 1'b1) begin
                            nxt_d.ph  = PH_CONVERT;
                            nxt_d.cnt = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                end
                PH_CONVERT: begin
                    if (tick) begin
                        if (cur_q.cnt == PHCNT_W'(CONV_CYCLES - 1)) begin
                            nxt_d.done = 1'b1;
                            nxt_d.cnt  = '0;
                            if (cont_en_i) begin
                                nxt_d.ph   = PH_SAMPLE;
                                nxt_d.div  = div_code_i;
                                nxt_d.slen = dec_len;
                            end else begin
                                nxt_d.ph = PH_IDLE;
                            end
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                end
                default: nxt_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.ph   <= PH_IDLE;
            cur_q.cnt  <= '0;
            cur_q.div  <= '0;
            cur_q.slen <= '0;
            cur_q.done <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sample_o  = (cur_q.ph == PH_SAMPLE);
    assign convert_o = (cur_q.ph == PH_CONVERT);
    assign busy_o    = (cur_q.ph != PH_IDLE);
    assign done_o    = cur_q.done;
endmodule

// File: rtl/adc_conv_sequencer_chk.sv
module adc_conv_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic abort_i,
    input logic clear_i,
    input logic sample_o,
    input logic convert_o,
    input logic busy_o,
    input logic done_o
);
    a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && convert_o));

    a_r4_convert_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && !abort_i) |=> (sample_o || convert_o));

    a_r5_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !abort_i) |=> (busy_o && sample_o));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i && !(start_i && !busy_o)) |=> done_o);

    a_r6_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_o && !abort_i) |=> (convert_o || done_o));

    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> (!busy_o && (done_o == $past(done_o && !clear_i))));
endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk u_chk (.*);

// File: tb/adc_conv_sequencer_test.sv
`timescale 1ns/1ps
module adc_conv_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, abort = 1'b0, clr = 1'b0, cont = 1'b0;
    logic [1:0] divc = '0;
    logic [2:0] lsc = '0;
    logic       sample_o, convert_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_conv_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .clear_i(clr),
        .div_code_i(divc), .ls_code_i(lsc), .cont_en_i(cont),
        .sample_o(sample_o), .convert_o(convert_o), .busy_o(busy_o), .done_o(done_o)
    );

    // div code, ls code, expected sample cycles, expected convert cycles
    localparam int VEC [7][4] = '{
        '{0, 4,   4,  20},
        '{0, 0,  24,  20},
        '{1, 1,  32,  40},
        '{2, 2,  40,  80},
        '{3, 3,  48, 160},
        '{3, 0, 192, 160},
        '{1, 7,   8,  40}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: plain, 1: change codes mid-sample, 2: start pulse mid-sample
    task automatic measure(input int dv, input int ls, input bit launch, input int mode,
                           output int ns, output int nc);
        if (launch) begin
            @(negedge clk);
            divc = 2'(dv); lsc = 3'(ls); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        ns = 0;
        while (sample_o) begin
            ns++;
            if (mode == 1 && ns == 3) begin divc = 2'd3; lsc = 3'd0; end
            if (mode == 2 && ns == 2) start = 1'b1;
            if (mode == 2 && ns == 3) start = 1'b0;
            @(negedge clk);
        end
        nc = 0;
        while (convert_o) begin
            nc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ns, nc;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 strobes", sample_o | convert_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            measure(VEC[i][0], VEC[i][1], 1'b1, 0, ns, nc);
            chk(VEC[i][1] >= 4 ? "R3 R1 sample length" : "R2 R1 sample length", ns, VEC[i][2]);
            chk("R4 R1 convert length", nc, VEC[i][3]);
            chk("R6 done set", done_o, 1);
            chk("R6 busy dropped", busy_o, 0);
        end

        // R6 sticky, then clear
        repeat (10) @(negedge clk);
        chk("R6 done sticky", done_o, 1);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R6 clear", done_o, 0);

        // R6 accepted start clears done
        measure(0, 4, 1'b1, 0, ns, nc);
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R6 start clears done", done_o, 0);
        chk("R5 busy after start", busy_o, 1);
        while (busy_o) @(negedge clk);

        // R9 codes held
        measure(1, 3, 1'b1, 1, ns, nc);
        chk("R9 sample held", ns, 12);
        chk("R9 convert held", nc, 40);

        // R5 start while busy ignored
        measure(0, 1, 1'b1, 2, ns, nc);
        chk("R5 sample unaffected", ns, 16);
        chk("R5 convert unaffected", nc, 20);
        chk("R5 idle after", busy_o, 0);

        // R8 abort from a fresh conversion
        @(negedge clk); divc = 2'd0; lsc = 3'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk("R8 abort idle", busy_o, 0);
        chk("R8 abort no done", done_o, 0);
        repeat (30) @(negedge clk);
        chk("R8 done still low", done_o, 0);

        // R7 continuous mode
        cont = 1'b1;
        measure(0, 4, 1'b1, 0, ns, nc);
        chk("R7 first sample", ns, 4);
        chk("R7 done set", done_o, 1);
        chk("R7 restarted", sample_o, 1);
        lsc = 3'd3;
        measure(0, 4, 1'b0, 0, ns, nc);
        chk("R7 second sample", ns, 4);
        chk("R7 done held", done_o, 1);
        measure(0, 4, 1'b0, 0, ns, nc);
        chk("R7 resampled code", ns, 6);
        chk("R7 convert", nc, 20);
        @(negedge clk);
        abort = 1'b1; @(negedge clk); abort = 1'b0; cont = 1'b0;
        chk("R8 abort stops continuous", busy_o, 0);
        chk("R8 done unchanged", done_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule